// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier with Exception Flags

This block multiplies two binary32 values and returns their product rounded to nearest, with ties going to the even significand. It is purely combinational: the product and the five exception indications follow the operands with no clock and no stored state. A surrounding unit that wants sticky status ORs the flags into its own register.

Each operand is sorted into one of six classes: zero, subnormal, normal, infinity, quiet NaN or signalling NaN. Subnormal inputs are normalised before the 24x24 significand product is formed. The 48-bit product is normalised, shifted right into the subnormal range when needed, rounded with guard and sticky bits, and renormalised when rounding carries out. Infinities, zeros and NaNs bypass the arithmetic path. Every NaN result is the canonical quiet NaN 0x7fc00000. The divide-by-zero output exists so the flag set is complete, and it never rises for multiplication.

The style's valid/ready stream interface does not suit a block with no timing of its own, so the operands and results are plain signals.

Top module: `fpm_mul32`

## Requirements
- R1: For two finite nonzero operands, the result equals the exact product rounded to nearest-even in binary32 (sign bit 31, exponent bits 30:23 with bias 127, fraction bits 22:0).
- R2: A NaN operand (exponent 0xff, nonzero fraction) whose fraction bit 22 is 0 is signalling; any signalling NaN input raises flag_invalid and gives result 0x7fc00000.
- R3: When at least one input is a NaN and no input is a signalling NaN, the result is 0x7fc00000 and flag_invalid stays low.
- R4: Infinity times zero, in either order and with any signs, raises flag_invalid and gives 0x7fc00000.
- R5: Infinity times a nonzero non-NaN value gives an infinity, and zero times a finite value gives a zero. In both cases the sign is the XOR of the input signs and all flags stay low.
- R6: When the rounded magnitude exceeds the largest finite value, flag_overflow and flag_inexact rise and the result is an infinity with the XOR sign. An example is squaring magnitude 0x7f400000.
- R7: flag_underflow rises only when the result is subnormal (exponent field 0, nonzero fraction) and inexact. An inexact result rounded to zero raises flag_inexact alone, with the XOR sign. An exact subnormal result raises no flag. A normal operand with exponent below 0x60 times a subnormal gives flag_inexact and either flag_underflow or a zero.
- R8: Subnormal operands take part with their full precision. A product that is exactly representable is returned exact with no flag.
- R9: flag_divzero is always low.
- R10: flag_inexact is high exactly when the rounded result differs from the exact product, including on overflow. An infinite result without overflow has it low.
- R11: A rounding carry renormalises the result: into the next binade for normal results, and from the largest subnormal into the smallest normal value 0x00800000 with no underflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First binary32 operand |
| op_b | input | 32 | Second binary32 operand |
| result | output | 32 | Rounded binary32 product |
| flag_invalid | output | 1 | Invalid operation |
| flag_divzero | output | 1 | Divide-by-zero, always low |
| flag_overflow | output | 1 | Rounded result exceeded the finite range |
| flag_underflow | output | 1 | Subnormal result that is also inexact |
| flag_inexact | output | 1 | Rounded result differs from the exact product |

## Verification
The hardest cases to reach are at the edge of the subnormal range. These include ties that carry from the largest subnormal into the smallest normal, and products that round to zero rather than to a subnormal. Uniform random operands almost never land there. The stimulus therefore draws exponents from separate small, large and full ranges, so the operand sum falls near the bottom or top of the exponent range, and it mixes in subnormal, NaN, infinity and zero operands. Directed vectors then pin the exact tie, carry and flush points. Expected values come from an exact double-precision product rounded bit by bit in the bench.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  typedef enum logic [2:0] {
    CLS_ZERO,
    CLS_SUB,
    CLS_NORM,
    CLS_INF,
    CLS_QNAN,
    CLS_SNAN
  } fp_class_e;
endpackage

// File: rtl/fpm_unpack.sv
module fpm_unpack
  import fpm_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int XW     = EXP_W + 3
) (
  input  logic [EXP_W+FRAC_W:0]  op,
  output logic                   sign,
  output fp_class_e              cls,
  output logic [FRAC_W:0]        sig,
  output logic signed [XW-1:0]   exp_s
);
  localparam int SW  = FRAC_W + 1;
  localparam int LZW = $clog2(SW + 1);

  logic [EXP_W-1:0]  expf;
  logic [FRAC_W-1:0] frac;
  logic [SW-1:0]     raw;
  logic [LZW-1:0]    lz;
  logic              hit;
  logic [XW-1:0]     e_base;

  assign sign = op[EXP_W+FRAC_W];
  assign expf = op[EXP_W+FRAC_W-1:FRAC_W];
  assign frac = op[FRAC_W-1:0];
  assign raw  = {(expf != '0), frac};

  always_comb begin
    if (expf == '1) begin
      if (frac == '0)          cls = CLS_INF;
      else if (frac[FRAC_W-1]) cls = CLS_QNAN;
      else                     cls = CLS_SNAN;
    end else if (expf == '0) begin
      cls = (frac == '0) ? CLS_ZERO : CLS_SUB;
    end else begin
      cls = CLS_NORM;
    end
  end

  // leading-zero count of the significand for subnormal normalisation
  always_comb begin
    lz  = '0;
    hit = 1'b0;
    for (int i = SW - 1; i >= 0; i--) begin
      if (!hit) begin
        if (raw[i]) hit = 1'b1;
        else        lz  = lz + 1'b1;
      end
    end
  end

  assign sig    = raw << lz;
  assign e_base = (expf == '0) ? XW'(1) : XW'(expf);
  assign exp_s  = e_base - XW'(lz);
endmodule

// File: rtl/fpm_sigmul.sv
module fpm_sigmul #(
  parameter int SW   = 24,
  parameter int XW   = 11,
  parameter int BIAS = 127
) (
  input  logic [SW-1:0]          sig_a,
  input  logic [SW-1:0]          sig_b,
  input  logic signed [XW-1:0]   exp_a,
  input  logic signed [XW-1:0]   exp_b,
  output logic [2*SW-1:0]        prod_norm,
  output logic signed [XW-1:0]   exp_r
);
  localparam int PW = 2 * SW;

  logic [PW-1:0] prod;
  logic          top;

  assign prod      = PW'(sig_a) * PW'(sig_b);
  assign top       = prod[PW-1];
  assign prod_norm = top ? prod : {prod[PW-2:0], 1'b0};
  assign exp_r     = exp_a + exp_b - XW'(BIAS) + XW'(top);
endmodule

// File: rtl/fpm_round.sv
module fpm_round #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int XW     = EXP_W + 3
) (
  input  logic                        sign,
  input  logic [2*(FRAC_W+1)-1:0]     prod,
  input  logic signed [XW-1:0]        exp_r,
  output logic [EXP_W+FRAC_W:0]       bits,
  output logic                        ovf,
  output logic                        inexact,
  output logic                        unf
);
  localparam int SW  = FRAC_W + 1;
  localparam int PW  = 2 * SW;
  localparam int EXW = 2 * PW;
  localparam logic signed [XW-1:0] ONE_S   = XW'(1);
  localparam logic signed [XW-1:0] MAXSH_S = XW'(SW + 2);
  localparam logic signed [XW-1:0] EMAX_S  = XW'((1 << EXP_W) - 1);

  logic signed [XW-1:0] sh_s;
  logic [XW-1:0]        sh;
  logic [EXW-1:0]       ext;
  logic [SW-1:0]        kept;
  logic                 guard, sticky, inc, lost;
  logic [SW:0]          rnd;
  logic signed [XW-1:0] e_eff, e_fin;
  logic [FRAC_W-1:0]    frac;

  // right shift into the subnormal range, capped once all bits reach sticky
  always_comb begin
    if (exp_r < ONE_S) begin
      sh_s  = ONE_S - exp_r;
      e_eff = ONE_S;
    end else begin
      sh_s  = '0;
      e_eff = exp_r;
    end
    sh = (sh_s > MAXSH_S) ? MAXSH_S : sh_s;
  end

  assign ext    = {prod, {PW{1'b0}}} >> sh;
  assign kept   = ext[EXW-1 -: SW];
  assign guard  = ext[EXW-SW-1];
  assign sticky = |ext[EXW-SW-2:0];
  assign lost   = guard | sticky;
  assign inc    = guard & (sticky | kept[0]);
  assign rnd    = {1'b0, kept} + (SW+1)'(inc);

  always_comb begin
    if (rnd[SW]) begin
      e_fin = e_eff + ONE_S;
      frac  = '0;
    end else if (rnd[SW-1]) begin
      e_fin = e_eff;
      frac  = rnd[FRAC_W-1:0];
    end else begin
      e_fin = '0;
      frac  = rnd[FRAC_W-1:0];
    end
  end

  always_comb begin
    ovf     = (e_fin >= EMAX_S);
    inexact = lost | ovf;
    unf     = lost && (e_fin == '0) && (frac != '0);
    if (ovf) bits = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    else     bits = {sign, e_fin[EXP_W-1:0], frac};
  end
endmodule

// File: rtl/fpm_mul32.sv
module fpm_mul32
  import fpm_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] op_a,
  input  logic [EXP_W+FRAC_W:0] op_b,
  output logic [EXP_W+FRAC_W:0] result,
  output logic                  flag_invalid,
  output logic                  flag_divzero,
  output logic                  flag_overflow,
  output logic                  flag_underflow,
  output logic                  flag_inexact
);
  localparam int W    = EXP_W + FRAC_W + 1;
  localparam int SW   = FRAC_W + 1;
  localparam int XW   = EXP_W + 3;
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic [W-1:0]         ops   [2];
  logic                 sgn   [2];
  fp_class_e            cls   [2];
  logic [SW-1:0]        sig   [2];
  logic signed [XW-1:0] exps  [2];

  assign ops[0] = op_a;
  assign ops[1] = op_b;

  for (genvar g = 0; g < 2; g++) begin : g_unp
    fpm_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .XW(XW)) u_unp (
      .op    (ops[g]),
      .sign  (sgn[g]),
      .cls   (cls[g]),
      .sig   (sig[g]),
      .exp_s (exps[g])
    );
  end

  logic [2*SW-1:0]      prod_norm;
  logic signed [XW-1:0] exp_r;
  logic                 p_sign;
  logic [W-1:0]         rnd_bits;
  logic                 r_ovf, r_nx, r_unf;

  assign p_sign = sgn[0] ^ sgn[1];

  fpm_sigmul #(.SW(SW), .XW(XW), .BIAS(BIAS)) u_sigmul (
    .sig_a     (sig[0]),
    .sig_b     (sig[1]),
    .exp_a     (exps[0]),
    .exp_b     (exps[1]),
    .prod_norm (prod_norm),
    .exp_r     (exp_r)
  );

  fpm_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .XW(XW)) u_round (
    .sign    (p_sign),
    .prod    (prod_norm),
    .exp_r   (exp_r),
    .bits    (rnd_bits),
    .ovf     (r_ovf),
    .inexact (r_nx),
    .unf     (r_unf)
  );

  logic any_snan, any_nan, any_inf, any_zero;

  assign any_snan = (cls[0] == CLS_SNAN) || (cls[1] == CLS_SNAN);
  assign any_nan  = any_snan || (cls[0] == CLS_QNAN) || (cls[1] == CLS_QNAN);
  assign any_inf  = (cls[0] == CLS_INF) || (cls[1] == CLS_INF);
  assign any_zero = (cls[0] == CLS_ZERO) || (cls[1] == CLS_ZERO);

  assign flag_divzero = 1'b0;

  always_comb begin
    result         = rnd_bits;
    flag_invalid   = 1'b0;
    flag_overflow  = 1'b0;
    flag_underflow = 1'b0;
    flag_inexact   = 1'b0;
    if (any_nan) begin
      result       = QNAN;
      flag_invalid = any_snan;
    end else if (any_inf && any_zero) begin
      result       = QNAN;
      flag_invalid = 1'b1;
    end else if (any_inf) begin
      result = {p_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    end else if (any_zero) begin
      result = {p_sign, {(W-1){1'b0}}};
    end else begin
      flag_overflow  = r_ovf;
      flag_underflow = r_unf;
      flag_inexact   = r_nx;
    end
  end
endmodule

// File: rtl/fpm_mul32_chk.sv
module fpm_mul32_chk (
  input logic [31:0] op_a,
  input logic [31:0] op_b,
  input logic [31:0] result,
  input logic        flag_invalid,
  input logic        flag_divzero,
  input logic        flag_overflow,
  input logic        flag_underflow,
  input logic        flag_inexact
);
  logic a_nan, b_nan, a_snan, b_snan, r_inf;

  assign a_nan  = (op_a[30:23] == 8'hff) && (op_a[22:0] != '0);
  assign b_nan  = (op_b[30:23] == 8'hff) && (op_b[22:0] != '0);
  assign a_snan = a_nan && !op_a[22];
  assign b_snan = b_nan && !op_b[22];
  assign r_inf  = (result[30:0] == 31'h7f800000);

  always_comb begin
    assert_snan_invalid_R2: assert (!(a_snan || b_snan) || flag_invalid)
      else $error("signalling NaN input without invalid flag");
    assert_invalid_qnan_R2: assert (!flag_invalid || result == 32'h7fc00000)
      else $error("invalid flag without canonical quiet NaN");
    assert_quiet_nan_R3: assert (!((a_nan || b_nan) && !a_snan && !b_snan) ||
                                 (!flag_invalid && result == 32'h7fc00000))
      else $error("quiet NaN input mishandled");
    assert_overflow_inf_R6: assert (!flag_overflow ||
                                    (flag_inexact && r_inf && result[31] == (op_a[31] ^ op_b[31])))
      else $error("overflow without inexact signed infinity");
    assert_underflow_sub_R7: assert (!flag_underflow ||
                                     (flag_inexact && result[30:23] == '0 && result[22:0] != '0))
      else $error("underflow without inexact subnormal");
    assert_no_divzero_R9: assert (!flag_divzero)
      else $error("divide-by-zero raised by multiply");
    assert_inf_exact_R10: assert (!(r_inf && !flag_overflow) || !flag_inexact)
      else $error("exact infinity marked inexact");
  end
endmodule

bind fpm_mul32 fpm_mul32_chk u_chk (
  .op_a           (op_a),
  .op_b           (op_b),
  .result         (result),
  .flag_invalid   (flag_invalid),
  .flag_divzero   (flag_divzero),
  .flag_overflow  (flag_overflow),
  .flag_underflow (flag_underflow),
  .flag_inexact   (flag_inexact)
);

// File: tb/fpm_mul32_bench.sv
`timescale 1ns/1ps
module fpm_mul32_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] op_a, op_b, result;
  logic flag_invalid, flag_divzero, flag_overflow, flag_underflow, flag_inexact;
  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fpm_mul32 u_fpm_mul32 (
    .op_a(op_a), .op_b(op_b), .result(result),
    .flag_invalid(flag_invalid), .flag_divzero(flag_divzero),
    .flag_overflow(flag_overflow), .flag_underflow(flag_underflow),
    .flag_inexact(flag_inexact)
  );

  function automatic real to_real(input logic [31:0] x);
    int e, m;
    real r;
    e = int'(x[30:23]);
    m = (e == 0) ? int'(x[22:0]) : int'({1'b1, x[22:0]});
    r = $itor(m) * (2.0 ** (((e == 0) ? 1 : e) - 150));
    return x[31] ? -r : r;
  endfunction

  // returns {result, nv, dz, of, uf, nx}
  function automatic logic [36:0] model(input logic [31:0] a, input logic [31:0] b);
    logic s, a_nan, b_nan, a_sn, b_sn, a_inf, b_inf, a_zero, b_zero;
    logic [63:0] d, mm, kept, rem, half;
    int de, fe, sh, ef;
    logic of, nx, uf;
    logic [22:0] fr;
    s      = a[31] ^ b[31];
    a_nan  = (a[30:23] == 8'hff) && (a[22:0] != 0);
    b_nan  = (b[30:23] == 8'hff) && (b[22:0] != 0);
    a_sn   = a_nan && !a[22];
    b_sn   = b_nan && !b[22];
    a_inf  = (a[30:0] == 31'h7f800000);
    b_inf  = (b[30:0] == 31'h7f800000);
    a_zero = (a[30:0] == 0);
    b_zero = (b[30:0] == 0);
    if (a_nan || b_nan) return {32'h7fc00000, a_sn || b_sn, 4'b0};
    if ((a_inf && b_zero) || (a_zero && b_inf)) return {32'h7fc00000, 1'b1, 4'b0};
    if (a_inf || b_inf) return {s, 31'h7f800000, 5'b0};
    if (a_zero || b_zero) return {s, 31'h0, 5'b0};
    d  = $realtobits(to_real(a) * to_real(b));
    de = int'(d[62:52]) - 1023;
    mm = {11'b0, 1'b1, d[51:0]};
    fe = de + 127;
    sh = (fe >= 1) ? 29 : (-97 - de);
    if (sh > 60) sh = 60;
    kept = mm >> sh;
    rem  = mm & ((64'd1 << sh) - 64'd1);
    half = 64'd1 << (sh - 1);
    if (rem > half || (rem == half && kept[0])) kept = kept + 64'd1;
    nx = (rem != 0);
    if (fe >= 1) begin
      if (kept[24]) begin kept = kept >> 1; fe = fe + 1; end
      ef = fe;
    end else begin
      ef = kept[23] ? 1 : 0;
    end
    fr = kept[22:0];
    of = (ef >= 255);
    if (of) return {s, 31'h7f800000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1};
    uf = nx && (ef == 0) && (fr != 0);
    return {s, ef[7:0], fr, 1'b0, 1'b0, 1'b0, uf, nx};
  endfunction

  task automatic check(input logic [31:0] a, input logic [31:0] b, input string tag);
    logic [36:0] exp_v, act_v;
    @(posedge clk);
    op_a = a;
    op_b = b;
    @(negedge clk);
    exp_v = model(a, b);
    act_v = {result, flag_invalid, flag_divzero, flag_overflow, flag_underflow, flag_inexact};
    n_checks++;
    if (act_v !== exp_v) begin
      n_errors++;
      $display("FAIL %s a=%h b=%h actual=%h nv%b dz%b of%b uf%b nx%b expected=%h nv%b dz%b of%b uf%b nx%b",
               tag, a, b, act_v[36:5], act_v[4], act_v[3], act_v[2], act_v[1], act_v[0],
               exp_v[36:5], exp_v[4], exp_v[3], exp_v[2], exp_v[1], exp_v[0]);
    end
  endtask

  function automatic logic [31:0] gen_op();
    logic s;
    logic [22:0] f;
    int e;
    s = 1'($urandom);
    f = 23'($urandom);
    case ($urandom % 10)
      0: return {s, 31'h0};
      1: return {s, 8'h00, (f == 0) ? 23'd1 : f};
      2: return {s, 31'h7f800000};
      3: return {s, 8'hff, 1'b1, f[21:0]};
      4: return {s, 8'hff, 1'b0, (f[21:0] == 0) ? 22'd5 : f[21:0]};
      5, 6: begin e = 20 + int'($urandom % 90); return {s, e[7:0], f}; end
      7: begin e = 150 + int'($urandom % 105); return {s, e[7:0], f}; end
      default: begin e = 1 + int'($urandom % 254); return {s, e[7:0], f}; end
    endcase
  endfunction

  initial begin
    op_a = 32'h0;
    op_b = 32'h0;
    void'($urandom(32'd20260117));
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_checks++;
    if ({result, flag_invalid, flag_divzero, flag_overflow, flag_underflow, flag_inexact} !== 37'h0) begin
      n_errors++;
      $display("FAIL R5 reset-time zero product actual=%h expected=00000000 no flags", result);
    end
    rst = 1'b0;
    // R2 signalling NaN
    check(32'h7f800001, 32'h3f800000, "R2");
    check(32'h3f800000, 32'hffa00000, "R2");
    check(32'h7fa00000, 32'h7fc00000, "R2");
    // R3 quiet NaN only
    check(32'h7fc00000, 32'h7fc12345, "R3");
    check(32'hffc00001, 32'h7f800000, "R3");
    check(32'h00000000, 32'h7fc00000, "R3");
    // R4 infinity times zero
    check(32'h7f800000, 32'h00000000, "R4");
    check(32'h80000000, 32'hff800000, "R4");
    // R5 infinity and zero operands
    check(32'hff800000, 32'h40000000, "R5");
    check(32'h80000000, 32'h3f800000, "R5");
    check(32'h7f800000, 32'h00000001, "R5");
    // R6 overflow
    check(32'h7f400000, 32'h7f400000, "R6");
    check(32'hff400000, 32'h7f400000, "R6");
    // R7 underflow and flush
    check(32'h2f800000, 32'h00400001, "R7");
    check(32'h00000003, 32'h3f000000, "R7");
    check(32'h00000004, 32'h3f000000, "R7");
    check(32'h80000001, 32'h3e800000, "R7");
    // R8 subnormal operands exact
    check(32'h00000001, 32'h4b000000, "R8");
    check(32'h00123456, 32'h40000000, "R8");
    // R9 divide-by-zero never raised
    check(32'h3f800000, 32'h00000000, "R9");
    // R10 inexact and tie to even
    check(32'h3f800000, 32'h3f800000, "R10");
    check(32'h3f800001, 32'h3f800001, "R10");
    check(32'h3f800001, 32'h3fc00000, "R10");
    // R11 rounding carries
    check(32'h3fffffff, 32'h3f800001, "R11");
    check(32'h007fffff, 32'h3f800001, "R11");
    // R1 random mix
    for (int i = 0; i < 4000; i++) check(gen_op(), gen_op(), "R1");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule